// File: doc/BRIEF.md
# Dissemination Barrier Flag Network

This block synchronizes P participants with a dissemination barrier. Each participant pulses its `arrive` input when it reaches the barrier. It then passes through R = ceil(log2 P) rounds. In round k, participant i writes a flag owned by participant (i + 2^k) mod P. It then waits until its own round-k flag has been written by participant (i - 2^k) mod P. After the last round, the participant raises its `done` output for a single cycle and is past the barrier.

Each flag bit has exactly one writer, fixed when the design is elaborated, and flags are only written and read, never read-modified-written. The flags are kept in two banks. Each participant selects a bank by a parity bit that toggles every episode, and writes a sense value that inverts every second episode. Flags left over from the previous episode therefore never satisfy a wait in the current one. P may be any value of 2 or more; the partner index wraps modulo P.

Top module: `dbar_net`

## Requirements
- R1: With R = ceil(log2 P), any participant whose arrival is the last one (sampled at rising edge L) shows `done` high in the cycle after edge L+2R. When all participants arrive on the same edge, all of them show `done` in that cycle.
- R2: Round timing of a participant:
  - It enters round k at edge s and writes the round-k flag of participant (i + 2^k) mod P at edge s+1.
  - It leaves round k at the first edge later than both s+1 and the edge at which its own round-k flag was written.
  - Round 0 is entered at the edge that samples `arrive`, and `done` follows the edge at which the last round is left.
- R3: A participant waiting in a round stays in that round for as long as its own flag for that round does not hold the current sense value.
- R4: Each participant raises `done` for exactly one cycle per episode, and at no other time.
- R5: No participant raises `done` at or before the edge that samples the last arrival of the episode, however long that arrival is delayed.
- R6: An `arrive` pulse is ignored while its participant is inside the barrier and not showing `done`. An `arrive` pulse in the cycle that `done` is high starts the next episode.
- R7: Episodes may follow one another without a gap. The flag bank in use alternates every episode, and stale flags from earlier episodes never release a wait.
- R8: After reset, all `done` outputs are low, all flags are clear and every participant is idle.
- R9: P need not be a power of two; partner and source indices wrap modulo P for any P of 2 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| arrive | input | P | Per-participant one-cycle arrival pulse |
| done | output | P | Per-participant one-cycle pulse when past the barrier |

## Verification
Two functions can fall in the same cycle: a participant can finish an episode while it arrives for the next one, and the same flag can be read for a wait in the cycle it is written. Episodes are run back to back with a zero gap, so the last arrivers of one episode re-arrive in their `done` cycle. Arrival skews are swept so that flags are sometimes written just as their owner begins to wait. Each `done` edge is judged against a round-by-round timing model computed in the bench from the partner rule, with a spare `arrive` pulse injected mid-barrier to confirm it changes nothing.

// File: rtl/dbar_pkg.sv
package dbar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SIG  = 2'd1,
    ST_WAIT = 2'd2,
    ST_FIN  = 2'd3
  } dbar_state_e;

  // participant that receives the round-k signal from participant i
  function automatic int dbar_partner(int i, int k, int p);
    return (i + (1 << k)) % p;
  endfunction

  // participant whose round-k signal lands on participant j
  function automatic int dbar_writer(int j, int k, int p);
    int found;
    found = 0;
    for (int m = 0; m < p; m++) begin
      if (dbar_partner(m, k, p) == j) found = m;
    end
    return found;
  endfunction

endpackage

// File: rtl/dbar_flag_bank.sv
module dbar_flag_bank
  import dbar_pkg::*;
#(
  parameter int P  = 5,
  parameter int R  = 3,
  parameter int RW = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [P-1:0]                  sig_en,
  input  logic [P-1:0][RW-1:0]          sig_round,
  input  logic [P-1:0]                  sig_par,
  input  logic [P-1:0]                  sig_val,
  output logic [1:0][P-1:0][R-1:0]      flags
);

  // every flag bit has a single statically known writer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        for (int j = 0; j < P; j++) begin
          for (int k = 0; k < R; k++) begin
            if (sig_en[dbar_writer(j, k, P)] &&
                sig_round[dbar_writer(j, k, P)] == RW'(k) &&
                sig_par[dbar_writer(j, k, P)] == b[0]) begin
              flags[b][j][k] <= sig_val[dbar_writer(j, k, P)];
            end
          end
        end
      end
    end
  end

  // R2, R9: a flag changes only after its modular source signalled that round and bank
  for (genvar gb = 0; gb < 2; gb++) begin : g_chk_b
    for (genvar gj = 0; gj < P; gj++) begin : g_chk_j
      for (genvar gk = 0; gk < R; gk++) begin : g_chk_k
        localparam int SRC = dbar_writer(gj, gk, P);
        a_r2_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
          !$stable(flags[gb][gj][gk]) |->
            $past(sig_en[SRC] && sig_round[SRC] == RW'(gk) && sig_par[SRC] == 1'(gb)));
      end
    end
  end

endmodule

// File: rtl/dbar_agent.sv
module dbar_agent
  import dbar_pkg::*;
#(
  parameter int R  = 3,
  parameter int RW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arrive,
  input  logic [1:0][R-1:0]    own_flags,
  output logic                 done,
  output logic                 sig_en,
  output logic [RW-1:0]        sig_round,
  output logic                 sig_par,
  output logic                 sig_val
);

  dbar_state_e       state_q;
  logic [RW-1:0]     round_q;
  logic              par_q;
  logic              sense_q;

  // named internal events
  logic flag_sel;
  logic flag_match;
  logic round_pass;
  logic last_round;
  logic start_ok;

  always_comb begin
    flag_sel = 1'b0;
    for (int k = 0; k < R; k++) begin
      if (round_q == RW'(k)) flag_sel = own_flags[par_q][k];
    end
  end

  assign flag_match = (flag_sel == sense_q);
  assign round_pass = (state_q == ST_WAIT) && flag_match;
  assign last_round = (round_q == RW'(R - 1));
  assign start_ok   = arrive && (state_q == ST_IDLE || state_q == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      round_q <= '0;
      par_q   <= 1'b0;
      sense_q <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            state_q <= ST_SIG;
            round_q <= '0;
          end
        end
        ST_SIG: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (round_pass) begin
            if (last_round) begin
              state_q <= ST_FIN;
            end else begin
              state_q <= ST_SIG;
              round_q <= round_q + RW'(1);
            end
          end
        end
        default: begin
          par_q <= ~par_q;
          if (par_q) sense_q <= ~sense_q;
          round_q <= '0;
          state_q <= start_ok ? ST_SIG : ST_IDLE;
        end
      endcase
    end
  end

  assign done      = (state_q == ST_FIN);
  assign sig_en    = (state_q == ST_SIG);
  assign sig_round = round_q;
  assign sig_par   = par_q;
  assign sig_val   = sense_q;

  // R3: no progress while the own flag lacks the current sense
  a_r3_hold_until_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !flag_match) |=> (state_q == ST_WAIT && $stable(round_q)));

  // R4: done is a single-cycle pulse
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: inside the barrier an agent never drops back to idle
  a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SIG || state_q == ST_WAIT) |=> (state_q != ST_IDLE));

  // R7: bank parity alternates at every completed episode
  a_r7_parity_flips: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (par_q != $past(par_q)));

endmodule

// File: rtl/dbar_net.sv
module dbar_net
  import dbar_pkg::*;
#(
  parameter int P = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [P-1:0] arrive,
  output logic [P-1:0] done
);

  localparam int R  = (P > 1) ? $clog2(P) : 1;
  localparam int RW = (R > 1) ? $clog2(R) : 1;

  logic [P-1:0]             sig_en;
  logic [P-1:0][RW-1:0]     sig_round;
  logic [P-1:0]             sig_par;
  logic [P-1:0]             sig_val;
  logic [1:0][P-1:0][R-1:0] flags;

  dbar_flag_bank #(.P(P), .R(R), .RW(RW)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_en    (sig_en),
    .sig_round (sig_round),
    .sig_par   (sig_par),
    .sig_val   (sig_val),
    .flags     (flags)
  );

  for (genvar g = 0; g < P; g++) begin : g_agent
    dbar_agent #(.R(R), .RW(RW)) u_agent (
      .clk       (clk),
      .rst_n     (rst_n),
      .arrive    (arrive[g]),
      .own_flags ({flags[1][g], flags[0][g]}),
      .done      (done[g]),
      .sig_en    (sig_en[g]),
      .sig_round (sig_round[g]),
      .sig_par   (sig_par[g]),
      .sig_val   (sig_val[g])
    );
  end

  // R8: nothing is past the barrier in the first cycle after reset
  a_r8_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (done == '0));

endmodule

// File: tb/dbar_net_bench.sv
module dbar_net_bench;

  localparam int P = 5;
  localparam int R = $clog2(P);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [P-1:0] arrive = '0;
  logic [P-1:0] done;

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  dbar_net #(.P(P)) u_dbar_net (
    .clk    (clk),
    .rst_n  (rst_n),
    .arrive (arrive),
    .done   (done)
  );

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;

  int  off [P];
  int  a   [P];
  int  e   [P];
  int  pe  [P];
  int  r1  [P];
  int  pr1 [P];
  int  cur [P];
  int  nxt [P];
  int  wre [P];
  int  base, cur_l, xa;
  bit  in_ep = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp,
                       input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (edge %0d)", req, what, act, exp, cyc);
    end
  endtask

  // source of participant j's round-k flag: step back by 2^k, wrapping modulo P
  function automatic int src_of(int j, int k);
    return (j + P - ((1 << k) % P)) % P;
  endfunction

  // one observed cycle: judge done for edge n, then drive arrive for edge n+1
  task automatic step();
    int n;
    n = cyc;
    for (int i = 0; i < P; i++) begin
      if (n == e[i] || n == pe[i]) begin
        check(done[i] == 1'b1, "R2,R9", int'(done[i]), 1, $sformatf("done of agent %0d at model edge", i));
        if (i == xa && n == e[i])
          check(done[i] == 1'b1, "R6", int'(done[i]), 1, "done of agent given a spare arrive");
      end else if (done[i]) begin
        check(1'b0, (in_ep && n <= cur_l) ? "R5" : "R4", 1, 0,
              $sformatf("unexpected done agent %0d", i));
      end
      if (n == r1[i] || n == pr1[i])
        check(done[i] == 1'b1, "R1", int'(done[i]), 1, $sformatf("last arriver %0d done at L+2R", i));
    end
    if (in_ep && n == cur_l)
      check(done == '0, "R5", int'(done), 0, "done at the last arrival edge");
    for (int i = 0; i < P; i++)
      arrive[i] = in_ep && ((a[i] == n + 1) || (i == xa && n + 1 == base + 1));
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < P; i++) begin
      e[i] = -1; pe[i] = -1; r1[i] = -1; pr1[i] = -1; a[i] = -1;
    end
    xa = -1;
    cur_l = 0;
    base = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      check(done == '0, "R8", int'(done), 0, "done after reset");
    end

    for (int ep = 0; ep < 29; ep++) begin
      int mx;
      for (int i = 0; i < P; i++) begin
        pe[i] = e[i];
        pr1[i] = r1[i];
        if (ep >= 24) off[i] = (i == ep - 24) ? 20 : 0;
        else if (ep % 6 == 0) off[i] = 0;
        else off[i] = (ep * 5 + i * 3 + (ep / 2) * i * i) % (ep % 6 + 1);
      end
      base = cyc + 1 + (ep % 3);
      mx = 0;
      for (int i = 0; i < P; i++) if (off[i] > mx) mx = off[i];
      cur_l = base + mx;
      xa = 0;
      for (int i = P - 1; i >= 0; i--) if (off[i] == 0) xa = i;
      // round-by-round timing model
      for (int i = 0; i < P; i++) begin
        a[i] = base + off[i];
        cur[i] = a[i];
      end
      for (int k = 0; k < R; k++) begin
        for (int i = 0; i < P; i++) wre[i] = cur[i] + 1;
        for (int i = 0; i < P; i++) begin
          int m;
          m = src_of(i, k);
          nxt[i] = ((wre[i] > wre[m]) ? wre[i] : wre[m]) + 1;
        end
        for (int i = 0; i < P; i++) cur[i] = nxt[i];
      end
      for (int i = 0; i < P; i++) begin
        e[i] = cur[i];
        r1[i] = (off[i] == mx) ? cur_l + 2 * R : -1;
      end
      in_ep = 1;
      // R7: next episode starts right after, so last arrivers re-arrive in their done cycle
      while (cyc < cur_l + 2 * R) step();
    end

    in_ep = 0;
    for (int i = 0; i < P; i++) begin
      pe[i] = e[i]; pr1[i] = r1[i]; e[i] = -1; r1[i] = -1;
    end
    for (int t = 0; t < 8; t++) step();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R4 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule